// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block is the digital control core of a successive-approximation converter, modelled at cycle level. A falling edge on the active-low start input begins a conversion. The block captures the sample word presented by the analog model together with the speed mode and the output format. It holds `busy` high for the conversion window and writes the formatted 18-bit word into the result register one cycle before `busy` drops, so the falling edge of `busy` can serve as a data-ready strobe. An acquisition window follows, and the block takes no new start until that window has ended.

Every window is a parameter in nanoseconds and is rounded up to whole cycles of the reference clock. The fast mode has a conversion window of 340 ns and an acquisition window of 70 ns, which are 34 and 7 cycles at 100 MHz. The accurate mode has 465 ns and 100 ns, which are 47 and 10 cycles. The fast mode also has a longest allowed gap between conversion starts. When a fast-mode conversion is followed by a longer gap, a sticky warning is raised. The power-down input holds the sequencer idle. The result is a held register rather than a stream: a downstream reader takes it on the falling edge of `busy`, and nothing ever stalls the block.

Top module: `sar_conv_seq`

## Requirements
- R1: While `rst_n` is low and right after it is released, `busy`, `result` and `acc_warn` are all zero.
- R2: The block sees a start when `start_n` is high at one rising clock edge and low at the next. If the block is idle and not powered down, `busy` is high after that edge. The block captures `sample_in`, `warp_sel` and `fmt_straight` at that same edge, so later changes to these inputs do not affect the conversion.
- R3: `busy` stays high for exactly ceil(conversion ns / clock period) cycles. With the default parameters this is 34 cycles when `warp_sel` was 1 at the start and 47 cycles when it was 0.
- R4: `result` takes its new value one cycle before `busy` falls, and it changes at no other time.
- R5: When the captured `fmt_straight` is 1, `result` equals the captured sample. When it is 0, `result` is the sample with bit 17 inverted and all other bits unchanged.
- R6: The block ignores a start that arrives while `busy` is high. It also ignores a start during the acquisition window that follows: 7 cycles in fast mode and 10 in accurate mode at defaults, with the start seen on the last cycle of the window still ignored. The block accepts a start on the first cycle after the window ends.
- R7: The warning applies after a conversion that started with `warp_sel` = 1. `acc_warn` becomes 1 when more than WARP_IDLE_NS / clock period cycles pass without a new start; a gap of exactly that many cycles does not raise it. Once raised, `acc_warn` stays 1 until reset.
- R8: When the last conversion started with `warp_sel` = 0, an idle gap of any length leaves `acc_warn` at 0.
- R9: When `pwr_down` is 1 at a clock edge, `busy` is low after that edge and any conversion in progress is abandoned with `result` left unchanged. Starts are ignored while `pwr_down` is 1, the idle-gap measurement is disarmed, and normal conversions resume after `pwr_down` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_n | input | 1 | Convert-start strobe; a falling edge begins a conversion |
| warp_sel | input | 1 | 1 selects fast mode, 0 selects accurate mode |
| fmt_straight | input | 1 | 1 selects straight binary, 0 selects two's complement (bit 17 inverted) |
| pwr_down | input | 1 | Holds the sequencer idle |
| sample_in | input | 18 | Sample word from the analog model |
| busy | output | 1 | High during the conversion window |
| result | output | 18 | Held conversion result |
| acc_warn | output | 1 | Sticky fast-mode idle-gap warning |

## Verification
Random conversions vary the sample word, the mode and the format. The sample input is scrambled right after each start, so a design that reads `sample_in` late gives the wrong result. Counting `busy` in both modes tells the two window lengths apart, and every conversion carries two start pulses that must be ignored: one during `busy` and one on the last acquisition cycle. Directed runs space starts exactly at the fast-mode limit and one cycle past it, and hold a long gap after an accurate-mode conversion, which separates the correct threshold from an off-by-one and from a warning that ignores the mode. A power-down in the middle of a conversion checks that the block aborts and that the old result is kept.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_CONV = 2'd1,
    SQ_ACQ  = 2'd2
  } sq_state_e;

  // Round a window given in nanoseconds up to whole clock cycles.
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ps);
    longint unsigned num;
    num = longint'(ns) * 64'd1000 + longint'(clk_ps) - 64'd1;
    return 32'(num / longint'(clk_ps));
  endfunction

endpackage

// File: rtl/sar_start_edge.sv
module sar_start_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic start_n,
  output logic start_fall
);

  logic level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b1;
    else        level_q <= start_n;
  end

  assign start_fall = level_q & ~start_n;

endmodule

// File: rtl/sar_seq_core.sv
module sar_seq_core
  import sar_seq_pkg::*;
#(
  parameter int unsigned RES_W = 18,
  parameter int unsigned WCONV = 34,
  parameter int unsigned WACQ  = 7,
  parameter int unsigned NCONV = 47,
  parameter int unsigned NACQ  = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_fall,
  input  logic             pwr_down,
  input  logic             warp_sel,
  input  logic             fmt_straight,
  input  logic [RES_W-1:0] sample_in,
  output logic             busy,
  output logic             start_ok,
  output logic             warp_last,
  output logic [RES_W-1:0] result
);

  localparam int unsigned MAX_CONV = (WCONV > NCONV) ? WCONV : NCONV;
  localparam int unsigned MAX_ACQ  = (WACQ > NACQ) ? WACQ : NACQ;
  localparam int unsigned MAX_WIN  = (MAX_CONV > MAX_ACQ) ? MAX_CONV : MAX_ACQ;
  localparam int unsigned CW       = $clog2(MAX_WIN + 1);

  localparam logic [CW-1:0] WCONV_L = CW'(WCONV - 1);
  localparam logic [CW-1:0] NCONV_L = CW'(NCONV - 1);
  localparam logic [CW-1:0] WACQ_L  = CW'(WACQ - 1);
  localparam logic [CW-1:0] NACQ_L  = CW'(NACQ - 1);

  sq_state_e        st_q;
  logic [CW-1:0]    cnt_q;
  logic             mode_q;
  logic             fmt_q;
  logic [RES_W-1:0] samp_q;
  logic [RES_W-1:0] res_q;
  logic [RES_W-1:0] res_d;

  // Two's complement view flips only the top bit.
  always_comb begin
    res_d = samp_q;
    if (!fmt_q) res_d[RES_W-1] = ~samp_q[RES_W-1];
  end

  assign start_ok = start_fall & (st_q == SQ_IDLE) & ~pwr_down;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      cnt_q  <= '0;
      mode_q <= 1'b0;
      fmt_q  <= 1'b1;
      samp_q <= '0;
      res_q  <= '0;
    end else if (pwr_down) begin
      st_q  <= SQ_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        SQ_IDLE: begin
          if (start_fall) begin
            st_q   <= SQ_CONV;
            cnt_q  <= warp_sel ? WCONV_L : NCONV_L;
            mode_q <= warp_sel;
            fmt_q  <= fmt_straight;
            samp_q <= sample_in;
          end
        end
        SQ_CONV: begin
          if (cnt_q == '0) begin
            st_q  <= SQ_ACQ;
            cnt_q <= mode_q ? WACQ_L : NACQ_L;
          end else begin
            cnt_q <= cnt_q - CW'(1);
          end
          if (cnt_q == CW'(1)) res_q <= res_d;
        end
        SQ_ACQ: begin
          if (cnt_q == '0) st_q <= SQ_IDLE;
          else             cnt_q <= cnt_q - CW'(1);
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign busy      = (st_q == SQ_CONV);
  assign warp_last = mode_q;
  assign result    = res_q;

endmodule

// File: rtl/sar_idle_watch.sv
module sar_idle_watch #(
  parameter int unsigned IDLE_CYC = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_ok,
  input  logic pwr_down,
  input  logic warp_last,
  output logic acc_warn
);

  localparam int unsigned TW = $clog2(IDLE_CYC + 1);
  localparam logic [TW-1:0] LIM = TW'(IDLE_CYC);

  logic [TW-1:0] tmr_q;
  logic          armed_q;
  logic          warn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q   <= '0;
      armed_q <= 1'b0;
      warn_q  <= 1'b0;
    end else if (pwr_down) begin
      tmr_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      if (start_ok) begin
        armed_q <= 1'b1;
        tmr_q   <= '0;
      end else if (tmr_q != LIM) begin
        tmr_q <= tmr_q + TW'(1);
      end
      if (armed_q && warp_last && (tmr_q == LIM)) warn_q <= 1'b1;
    end
  end

  assign acc_warn = warn_q;

endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
  import sar_seq_pkg::*;
#(
  parameter int unsigned RES_W        = 18,
  parameter int unsigned CLK_PS       = 10000,
  parameter int unsigned WARP_CONV_NS = 340,
  parameter int unsigned WARP_ACQ_NS  = 70,
  parameter int unsigned NORM_CONV_NS = 465,
  parameter int unsigned NORM_ACQ_NS  = 100,
  parameter int unsigned WARP_IDLE_NS = 1000000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_n,
  input  logic             warp_sel,
  input  logic             fmt_straight,
  input  logic             pwr_down,
  input  logic [RES_W-1:0] sample_in,
  output logic             busy,
  output logic [RES_W-1:0] result,
  output logic             acc_warn
);

  localparam int unsigned WCONV    = ns_to_cyc(WARP_CONV_NS, CLK_PS);
  localparam int unsigned WACQ     = ns_to_cyc(WARP_ACQ_NS, CLK_PS);
  localparam int unsigned NCONV    = ns_to_cyc(NORM_CONV_NS, CLK_PS);
  localparam int unsigned NACQ     = ns_to_cyc(NORM_ACQ_NS, CLK_PS);
  localparam int unsigned IDLE_CYC = WARP_IDLE_NS * 1000 / CLK_PS;

  logic start_fall_w;
  logic start_ok_w;
  logic warp_last_w;

  sar_start_edge u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_n    (start_n),
    .start_fall (start_fall_w)
  );

  sar_seq_core #(
    .RES_W (RES_W),
    .WCONV (WCONV),
    .WACQ  (WACQ),
    .NCONV (NCONV),
    .NACQ  (NACQ)
  ) u_core (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_fall   (start_fall_w),
    .pwr_down     (pwr_down),
    .warp_sel     (warp_sel),
    .fmt_straight (fmt_straight),
    .sample_in    (sample_in),
    .busy         (busy),
    .start_ok     (start_ok_w),
    .warp_last    (warp_last_w),
    .result       (result)
  );

  sar_idle_watch #(
    .IDLE_CYC (IDLE_CYC)
  ) u_idle (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_ok  (start_ok_w),
    .pwr_down  (pwr_down),
    .warp_last (warp_last_w),
    .acc_warn  (acc_warn)
  );

endmodule

// File: rtl/sar_conv_seq_chk.sv
module sar_conv_seq_chk #(
  parameter int unsigned RES_W = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_n,
  input logic             pwr_down,
  input logic             busy,
  input logic [RES_W-1:0] result,
  input logic             acc_warn,
  input logic             warp_last,
  input logic [31:0]      conv_w,
  input logic [31:0]      conv_n
);

  logic [31:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_q <= '0;
    else if (busy) run_q <= run_q + 32'd1;
    else           run_q <= '0;
  end

  assert_start_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(!start_n) && !$past(pwr_down)));

  assert_busy_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !$past(pwr_down)) |-> (run_q == conv_w || run_q == conv_n));

  assert_result_only_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> busy);

  assert_acq_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |=> !busy);

  assert_warn_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_warn |=> acc_warn);

  assert_warn_fast_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acc_warn) |-> $past(warp_last));

  assert_pd_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> !busy);

endmodule

bind sar_conv_seq sar_conv_seq_chk #(.RES_W(RES_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_n   (start_n),
  .pwr_down  (pwr_down),
  .busy      (busy),
  .result    (result),
  .acc_warn  (acc_warn),
  .warp_last (warp_last_w),
  .conv_w    (32'(WCONV)),
  .conv_n    (32'(NCONV))
);

// File: tb/test_sar_conv_seq.sv
`timescale 1ns/1ps
module test_sar_conv_seq;

  localparam int IDLE_NS  = 5000;
  localparam int IDLE_CYC = IDLE_NS / 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_n = 1'b1;
  logic        warp_sel = 1'b0;
  logic        fmt_straight = 1'b1;
  logic        pwr_down = 1'b0;
  logic [17:0] sample_in = '0;
  logic        busy;
  logic [17:0] result;
  logic        acc_warn;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  time t_low = 0;

  always #5 clk = ~clk;

  sar_conv_seq #(.WARP_IDLE_NS(IDLE_NS)) i_sar_conv_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_n      (start_n),
    .warp_sel     (warp_sel),
    .fmt_straight (fmt_straight),
    .pwr_down     (pwr_down),
    .sample_in    (sample_in),
    .busy         (busy),
    .result       (result),
    .acc_warn     (acc_warn)
  );

  function automatic int cyc(input int ns);
    return (ns * 1000 + 9999) / 10000;
  endfunction

  function automatic logic [17:0] fmt_exp(input logic [17:0] s, input logic f);
    return f ? s : (s ^ 18'h20000);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // One conversion with an ignored start during busy and on the last acquisition cycle.
  task automatic run_conv(input logic [17:0] s, input logic w, input logic f);
    int n;
    int econv;
    int eacq;
    logic [17:0] last_busy_res;
    econv = w ? cyc(340) : cyc(465);
    eacq  = w ? cyc(70) : cyc(100);
    @(negedge clk);
    sample_in = s; warp_sel = w; fmt_straight = f; start_n = 1'b0;
    t_low = $time;
    @(negedge clk);
    start_n = 1'b1;
    sample_in = ~s;
    warp_sel = ~w;
    fmt_straight = ~f;
    chk(busy == 1'b1, "R2 busy after start", busy, 1);
    n = 0;
    last_busy_res = result;
    while (busy && n < 200) begin
      n++;
      last_busy_res = result;
      if (n == 3) start_n = 1'b0;
      if (n == 4) start_n = 1'b1;
      @(negedge clk);
    end
    chk(n == econv, "R3 busy length", n, econv);
    chk(last_busy_res == fmt_exp(s, f), "R4 result ready before busy falls", last_busy_res, fmt_exp(s, f));
    chk(result == fmt_exp(s, f), "R5 result format", result, fmt_exp(s, f));
    repeat (eacq - 1) @(negedge clk);
    start_n = 1'b0;
    @(negedge clk);
    start_n = 1'b1;
    chk(busy == 1'b0, "R6 start in acquisition ignored", busy, 0);
    @(negedge clk);
    chk(busy == 1'b0, "R6 still idle", busy, 0);
    chk(result == fmt_exp(s, f), "R4 result held after busy", result, fmt_exp(s, f));
  endtask

  task automatic wait_gap(input int g);
    while ((($time - t_low) / 10) < g - 1) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [17:0] saved;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(busy == 0 && result == 0 && acc_warn == 0, "R1 state in reset", {busy, result, acc_warn}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && result == 0 && acc_warn == 0, "R1 state after reset", {busy, result, acc_warn}, 0);

    // Directed format corners.
    run_conv(18'h00000, 1'b1, 1'b0);
    run_conv(18'h3FFFF, 1'b0, 1'b0);
    run_conv(18'h20000, 1'b1, 1'b1);
    run_conv(18'h1FFFF, 1'b0, 1'b1);

    for (int i = 0; i < 30; i++) begin
      run_conv(18'($urandom), 1'($urandom), 1'($urandom));
    end
    chk(acc_warn == 1'b0, "R7 no warning with short gaps", acc_warn, 0);

    // Accurate-mode conversion followed by a long gap.
    run_conv(18'h12345, 1'b0, 1'b1);
    wait_gap(IDLE_CYC + 200);
    chk(acc_warn == 1'b0, "R8 long gap after accurate mode", acc_warn, 0);

    // Fast mode: gap at the limit, then one past it.
    run_conv(18'h0ABCD, 1'b1, 1'b1);
    wait_gap(IDLE_CYC);
    run_conv(18'h11111, 1'b1, 1'b1);
    chk(acc_warn == 1'b0, "R7 gap at limit", acc_warn, 0);
    wait_gap(IDLE_CYC + 1);
    run_conv(18'h22222, 1'b1, 1'b0);
    chk(acc_warn == 1'b1, "R7 gap past limit", acc_warn, 1);
    run_conv(18'h33333, 1'b0, 1'b1);
    chk(acc_warn == 1'b1, "R7 warning sticky", acc_warn, 1);

    // Power-down in the middle of a conversion.
    saved = result;
    @(negedge clk);
    sample_in = 18'h05555; warp_sel = 1'b1; start_n = 1'b0;
    @(negedge clk);
    start_n = 1'b1;
    repeat (5) @(negedge clk);
    pwr_down = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R9 busy low in power-down", busy, 0);
    start_n = 1'b0;
    @(negedge clk);
    start_n = 1'b1;
    repeat (60) @(negedge clk);
    chk(busy == 1'b0, "R9 start ignored in power-down", busy, 0);
    chk(result == saved, "R9 result kept on abort", result, saved);
    pwr_down = 1'b0;
    repeat (2) @(negedge clk);
    run_conv(18'h2AAAA, 1'b0, 1'b0);

    // Reset clears the sticky warning.
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(acc_warn == 0 && result == 0, "R1 R7 reset clears warning", {acc_warn, result}, 0);

    summary();
  end

endmodule